// File: doc/BRIEF.md
# Power-of-Two Millisecond Input Debouncer

This block cleans up a group of slow external input pins before the rest of the chip uses them. Each pin first passes through a two-stage synchronizer. A filter cell then compares the synchronized level with the level it last accepted. A filtered pin takes a new level only once that level has been seen unchanged across a whole window of millisecond ticks. The ticks come from a shared 1 ms strobe that is generated elsewhere.

Each pin has its own 9-bit control word. A single enable bit turns the filter on. A 3-bit code selects the window as a power of two: code k gives 2^k ms, so the range is 1 ms to 128 ms. When the filter is off, the synchronized level goes to the output through one register. Any edit to the enable bit or the code throws away a count in progress. Bits of the control word outside these two fields have no effect.

Top module: `pin_debounce`

## Requirements
- R1: In a pin's control word, bit 8 enables filtering and bits 7:5 hold the rate code k. The window is 2^k ticks, so codes 0 to 7 give windows of 1 to 128 ticks.
- R2: The raw input passes through two synchronizer flops. A raw change made before a clock edge cannot reach the output before the third edge.
- R3: With filtering enabled, the output takes the new level on the clock edge that samples the 2^k-th tick counted while the synchronized input differs from the output. It stays unchanged on all earlier ticks.
- R4: If the synchronized input returns to the output level before the window completes, the partial count is discarded. A later divergence again needs a full 2^k ticks.
- R5: With filtering disabled, the output equals the synchronized input one clock later. A raw change therefore shows on the output after exactly three edges, whatever the tick does.
- R6: A change of the enable bit or the rate code restarts the count from zero. A tick that arrives in the same cycle as the change is not counted.
- R7: Control bits 4:0 are ignored. Changing them neither alters the window nor restarts a count in progress.
- R8: During reset the synchronizer, the counter and the output are all cleared. The output therefore equals the synchronized input (both 0).
- R9: Pins are filtered independently. Each pin flips at its own window while sharing the same tick.
- R10: While filtering is enabled, the output never changes on a cycle without a tick, however long the input stays diverged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe each millisecond |
| pin_raw | input | NUM_PINS | Asynchronous raw pin levels |
| pin_ctrl | input | NUM_PINS*9 | Per-pin control words; pin p uses bits p*9+8 down to p*9 |
| pin_filt | output | NUM_PINS | Filtered pin levels |

## Verification
Two things can happen in the same cycle: a control-word edit and a tick. The bench provokes this by rewriting the rate code of a pin in mid-window in exactly the cycle where it raises the tick. It then counts how many further ticks the output needs before it flips. The count must be the full new window, which shows that the coinciding tick was dropped and the count restarted. A second collision is checked separately: the completing tick of one pin landing together with ticks counted by pins on longer windows, which all share one strobe. The bench judges it by checking every pin after every tick of a 128-tick sweep.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  // Control word layout (fields decoded by the filter cell)
  localparam int CTRL_W   = 9;
  localparam int EN_BIT   = 8;
  localparam int RATE_LSB = 5;
  localparam int RATE_W   = 3;
  localparam int WIN_MAX  = 1 << ((1 << RATE_W) - 1);
  localparam int CNT_W    = $clog2(WIN_MAX + 1);

  typedef logic [RATE_W-1:0] rate_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  function automatic logic ctrl_en(input logic [CTRL_W-1:0] w);
    return w[EN_BIT];
  endfunction

  function automatic rate_t ctrl_rate(input logic [CTRL_W-1:0] w);
    return w[RATE_LSB +: RATE_W];
  endfunction

  // Window length in ticks for a rate code: 2^code
  function automatic cnt_t win_ticks(input rate_t code);
    return cnt_t'(1) << code;
  endfunction
endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dbf_cell.sv
module dbf_cell
  import dbf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              sync_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              filt_o
);
  logic               en;
  rate_t              rate;
  cnt_t               win;
  logic [RATE_W:0]    cfg_q;
  logic               cfg_change;
  logic               differs;
  logic               hit;
  cnt_t               cnt_q;
  logic               filt_q;
  logic               live_q;

  assign en         = ctrl_en(ctrl_i);
  assign rate       = ctrl_rate(ctrl_i);
  assign win        = win_ticks(rate);
  assign cfg_change = ({en, rate} != cfg_q);
  assign differs    = (sync_i != filt_q);
  assign hit        = (cnt_q == win - cnt_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      filt_q <= 1'b0;
      live_q <= 1'b0;
    end else begin
      cfg_q  <= {en, rate};
      live_q <= 1'b1;
      if (!en) begin
        filt_q <= sync_i;
        cnt_q  <= '0;
      end else if (!differs || cfg_change) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (hit) begin
          filt_q <= sync_i;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + cnt_t'(1);
        end
      end
    end
  end

  assign filt_o = filt_q;

  // Count stays inside the programmed window
  assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && en && !cfg_change) |-> (cnt_q < win));

  // Enabled filter holds its output on tick-free cycles
  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && en && !tick_i) |=> $stable(filt_q));

  // Disabled filter follows the synchronized level one clock later
  assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !en) |=> (filt_q == $past(sync_i)));

  // A configuration edit clears the count
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && cfg_change) |=> (cnt_q == '0));
endmodule

// File: rtl/pin_debounce.sv
module pin_debounce
  import dbf_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ms_tick,
  input  logic [NUM_PINS-1:0]        pin_raw,
  input  logic [NUM_PINS*CTRL_W-1:0] pin_ctrl,
  output logic [NUM_PINS-1:0]        pin_filt
);
  logic [NUM_PINS-1:0] pin_sync;

  dbf_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_raw),
    .q_o   (pin_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    dbf_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (ms_tick),
      .sync_i (pin_sync[p]),
      .ctrl_i (pin_ctrl[p*CTRL_W +: CTRL_W]),
      .filt_o (pin_filt[p])
    );
  end

  // Reset leaves output and synchronized level equal
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_equal_R8: assert (pin_filt == pin_sync || $isunknown(pin_filt));
    end
  end
endmodule

// File: tb/pin_debounce_tb.sv
module pin_debounce_tb;
  localparam int NP = 4;
  localparam int CW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic [NP-1:0] pin_raw = '0;
  logic [NP*CW-1:0] pin_ctrl = '0;
  logic [NP-1:0] pin_filt;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pin_debounce #(.NUM_PINS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .pin_raw(pin_raw), .pin_ctrl(pin_ctrl), .pin_filt(pin_filt)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  // Word layout: bit 8 enable, bits 7:5 code, bits 4:0 unused
  task automatic set_cfg(input int p, input bit en, input int code, input int extra);
    pin_ctrl[p*CW +: CW] = {en, 3'(code), 5'(extra)};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic o;
    logic newv;
    logic oldv;
    cyc(3);
    for (int p = 0; p < NP; p++) check("R8 in reset", pin_filt[p], 1'b0);
    rst_n = 1'b1;
    cyc(1);
    for (int p = 0; p < NP; p++) check("R8 after reset", pin_filt[p], 1'b0);

    // R2 / R5: bypass latency of three edges, tick irrelevant
    pin_raw[0] = 1'b1;
    ms_tick = 1'b1;
    cyc(1); check("R2 edge1", pin_filt[0], 1'b0);
    cyc(1); check("R2 edge2", pin_filt[0], 1'b0);
    cyc(1); check("R5 edge3", pin_filt[0], 1'b1);
    ms_tick = 1'b0;
    pin_raw[0] = 1'b0;
    cyc(3); check("R5 fall", pin_filt[0], 1'b0);

    // R1 / R3 / R9: all codes, all pins sharing the tick
    for (int r = 0; r < 2; r++) begin
      for (int p = 0; p < NP; p++) set_cfg(p, 1'b1, r*4 + p, 0);
      cyc(3);
      for (int d = 0; d < 2; d++) begin
        oldv = pin_filt[0];
        newv = ~oldv;
        pin_raw = {NP{newv}};
        cyc(3);
        for (int t = 1; t <= 128; t++) begin
          tick();
          for (int p = 0; p < NP; p++)
            check("R1 R3 R9 sweep", pin_filt[p],
                  (t >= (1 << (r*4 + p))) ? newv : oldv);
        end
      end
    end
    for (int p = 1; p < NP; p++) set_cfg(p, 1'b0, 0, 0);

    // R4: bounce discards partial count
    o = pin_filt[0];
    set_cfg(0, 1'b1, 2, 0); cyc(2);
    pin_raw[0] = ~o; cyc(3);
    repeat (3) tick();
    check("R4 partial", pin_filt[0], o);
    pin_raw[0] = o; cyc(3);
    check("R4 back", pin_filt[0], o);
    pin_raw[0] = ~o; cyc(3);
    repeat (3) tick();
    check("R4 restart", pin_filt[0], o);
    tick();
    check("R4 full", pin_filt[0], ~o);

    // R6: code edit coinciding with a tick
    o = pin_filt[0];
    pin_raw[0] = ~o; cyc(3);
    repeat (3) tick();
    set_cfg(0, 1'b1, 3, 0);
    tick();
    repeat (7) tick();
    check("R6 not yet", pin_filt[0], o);
    tick();
    check("R6 new window", pin_filt[0], ~o);

    // R7: unused bits ignored
    o = pin_filt[0];
    set_cfg(0, 1'b1, 1, 0); cyc(2);
    pin_raw[0] = ~o; cyc(3);
    tick();
    set_cfg(0, 1'b1, 1, 31); cyc(2);
    check("R7 held", pin_filt[0], o);
    tick();
    check("R7 no restart", pin_filt[0], ~o);

    // R10: no tick, no change
    o = pin_filt[0];
    set_cfg(0, 1'b1, 0, 0); cyc(2);
    pin_raw[0] = ~o; cyc(20);
    check("R10 held", pin_filt[0], o);
    tick();
    check("R10 tick", pin_filt[0], ~o);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule